// File: doc/BRIEF.md
# Masked Status Polling Match Engine

This block automates the repeated reading of a status word from an external memory device. Once started, it issues a one-cycle poll request, waits for the returned status word with its valid strobe, and compares the word against a match value under a bit mask. Two comparison rules are available: every unmasked bit must equal its match bit, or at least one unmasked bit must equal its match bit.

On a match the engine sets a sticky match flag and captures the status word that produced it. The flag drives an interrupt output when the interrupt enable is set. Software clears the flag with a one-cycle clear pulse.

The engine runs in one of two ways. It can stop by itself on the first match, or it can keep polling until an abort request arrives or the interface is disabled. It runs only while the interface is enabled and the two-bit function-mode field selects status polling. The serial transfer itself and any delay between polls are handled outside this block.

Top module: `status_poll_engine`

## Requirements
- R1: With `or_mode`=0, a result sets `match_flag` exactly when `((rsp_data ^ match_val) & mask) == 0`; with an all-zero mask every result matches.
- R2: With `or_mode`=1, a result sets `match_flag` exactly when `(~(rsp_data ^ match_val) & mask) != 0`; with an all-zero mask no result matches.
- R3: With `stop_on_match`=1, `busy` is low in the cycle after a matching result is accepted, and `poll_req` is not asserted again without a new `start`.
- R4: With `stop_on_match`=0, polling continues after a match; `abort` ends it, with `busy` low one cycle later and no further `poll_req`.
- R5: `irq` is high exactly when `match_flag` and `irq_en` are both high.
- R6: The engine starts only when `enable`=1 and `func_mode`=2'b10; a `start` under any other setting is ignored. Dropping either condition while busy ends polling, with `busy` low one cycle later.
- R7: `match_flag` stays set until a `flag_clr` pulse, and a match in the same cycle as `flag_clr` wins. `match_data` takes the matching status word and holds it through non-matching results.
- R8: `poll_req` is a one-cycle pulse. It comes in the cycle after an accepted `start` and in the cycle after each result that does not end polling. It is never asserted while a result is awaited.
- R9: After reset, `poll_req`, `busy`, `match_flag`, `irq` and `match_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Interface enable |
| func_mode | input | 2 | Functional mode; 2'b10 selects status polling |
| start | input | 1 | Begin a polling session |
| abort | input | 1 | Abort request |
| stop_on_match | input | 1 | 1: stop at first match; 0: poll until abort or disable |
| or_mode | input | 1 | 0: all unmasked bits must match; 1: any unmasked bit matching is enough |
| irq_en | input | 1 | Match interrupt enable |
| mask | input | STAT_W | Compare mask, 1 = bit takes part |
| match_val | input | STAT_W | Expected status bits |
| rsp_valid | input | 1 | Status word strobe |
| rsp_data | input | STAT_W | Received status word |
| flag_clr | input | 1 | Write-one clear of the match flag |
| poll_req | output | 1 | Request one status read |
| busy | output | 1 | Polling session active |
| match_flag | output | 1 | Sticky status-match flag |
| irq | output | 1 | Match interrupt |
| match_data | output | STAT_W | Status word captured at the last match |

## Verification
The hardest case to reach is a full mask-by-match-by-response product under both comparison rules, with the flag seen fresh for each response. The bench does this in a 4-bit configuration. For each mode, mask and match value it opens one continuous session and feeds all 16 responses. During every request cycle it clears the flag, so each result's flag is observed on its own. Collisions are placed one per cycle with negedge-driven stimulus: a clear landing on a matching result, an abort landing on an outstanding result, and a disable landing mid-session.

// File: rtl/spoll_pkg.sv
package spoll_pkg;
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_REQ  = 2'd1,
        PS_WAIT = 2'd2
    } poll_st_e;

    localparam logic [1:0] FMODE_POLL = 2'b10;
endpackage

// File: rtl/spoll_compare.sv
module spoll_compare #(
    parameter int STAT_W = 8
) (
    input  logic              or_mode,
    input  logic [STAT_W-1:0] mask,
    input  logic [STAT_W-1:0] match_val,
    input  logic [STAT_W-1:0] rsp_data,
    output logic              hit
);
    logic [STAT_W-1:0] eq_bits;

    always_comb begin
        eq_bits = ~(rsp_data ^ match_val) & mask;
        if (or_mode)
            hit = |eq_bits;
        else
            hit = (eq_bits == mask);
    end
endmodule

// File: rtl/spoll_ctrl.sv
module spoll_ctrl
    import spoll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic start,
    input  logic abort,
    input  logic stop_on_match,
    input  logic rsp_valid,
    input  logic hit,
    output logic poll_req,
    output logic busy,
    output logic take
);
    typedef struct packed {
        poll_st_e st;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        take  = 1'b0;
        case (ctl_q.st)
            PS_IDLE: if (active && start && !abort) ctl_d.st = PS_REQ;
            PS_REQ:  ctl_d.st = PS_WAIT;
            PS_WAIT: begin
                if (rsp_valid) begin
                    take     = 1'b1;
                    ctl_d.st = (hit && stop_on_match) ? PS_IDLE : PS_REQ;
                end
            end
            default: ctl_d.st = PS_IDLE;
        endcase
        if (ctl_q.st != PS_IDLE && (abort || !active)) begin
            ctl_d.st = PS_IDLE;
            take     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: PS_IDLE};
        else        ctl_q <= ctl_d;
    end

    assign poll_req = (ctl_q.st == PS_REQ);
    assign busy     = (ctl_q.st != PS_IDLE);

    // R8: request is a single-cycle pulse
    a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |=> !poll_req);
    // R3: a matching result under auto-stop ends the session
    a_r3_auto_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (take && hit && stop_on_match) |=> (!busy && !poll_req));
    // R4: abort ends the session with no further request
    a_r4_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (!busy && !poll_req));
    // R6: leaving polling mode or disabling ends the session
    a_r6_inactive_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !busy);
endmodule

// File: rtl/spoll_flag.sv
module spoll_flag #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic              clr,
    input  logic [STAT_W-1:0] din,
    output logic              flag,
    output logic [STAT_W-1:0] data
);
    typedef struct packed {
        logic              flag;
        logic [STAT_W-1:0] data;
    } flag_s;

    flag_s fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (clr) fl_d.flag = 1'b0;
        if (set) begin
            fl_d.flag = 1'b1;
            fl_d.data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flag = fl_q.flag;
    assign data = fl_q.data;

    // R7: flag stays set without a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    // R7: captured word only changes on a match
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !set |=> $stable(data));
    // R7: a match overrides a simultaneous clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
endmodule

// File: rtl/status_poll_engine.sv
module status_poll_engine
    import spoll_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        func_mode,
    input  logic              start,
    input  logic              abort,
    input  logic              stop_on_match,
    input  logic              or_mode,
    input  logic              irq_en,
    input  logic [STAT_W-1:0] mask,
    input  logic [STAT_W-1:0] match_val,
    input  logic              rsp_valid,
    input  logic [STAT_W-1:0] rsp_data,
    input  logic              flag_clr,
    output logic              poll_req,
    output logic              busy,
    output logic              match_flag,
    output logic              irq,
    output logic [STAT_W-1:0] match_data
);
    logic active;
    logic hit;
    logic take;
    logic set_match;

    assign active    = enable && (func_mode == FMODE_POLL);
    assign set_match = take && hit;

    spoll_compare #(.STAT_W(STAT_W)) u_cmp (
        .or_mode   (or_mode),
        .mask      (mask),
        .match_val (match_val),
        .rsp_data  (rsp_data),
        .hit       (hit)
    );

    spoll_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (active),
        .start         (start),
        .abort         (abort),
        .stop_on_match (stop_on_match),
        .rsp_valid     (rsp_valid),
        .hit           (hit),
        .poll_req      (poll_req),
        .busy          (busy),
        .take          (take)
    );

    spoll_flag #(.STAT_W(STAT_W)) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_match),
        .clr   (flag_clr),
        .din   (rsp_data),
        .flag  (match_flag),
        .data  (match_data)
    );

    assign irq = match_flag && irq_en;

    // R1: an AND-mode match leaves no unmasked bit different
    a_r1_and_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (set_match && !or_mode) |-> (((rsp_data ^ match_val) & mask) == '0));
    // R2: an OR-mode match needs a nonzero mask
    a_r2_or_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (set_match && or_mode) |-> (mask != '0));
    // R6: a start outside polling mode leaves the engine idle
    a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !active) |=> !busy);
endmodule

// File: tb/test_status_poll_engine.sv
module test_status_poll_engine;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [1:0] func_mode = 2'b00;
    logic start = 1'b0, abort = 1'b0, stop_on_match = 1'b0;
    logic or_mode = 1'b0, irq_en = 1'b0;
    logic [W-1:0] mask = '0, match_val = '0, rsp_data = '0;
    logic rsp_valid = 1'b0, flag_clr = 1'b0;
    logic poll_req, busy, match_flag, irq;
    logic [W-1:0] match_data;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    status_poll_engine #(.STAT_W(W)) i_status_poll_engine (
        .clk(clk), .rst_n(rst_n), .enable(enable), .func_mode(func_mode),
        .start(start), .abort(abort), .stop_on_match(stop_on_match),
        .or_mode(or_mode), .irq_en(irq_en), .mask(mask), .match_val(match_val),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .flag_clr(flag_clr),
        .poll_req(poll_req), .busy(busy), .match_flag(match_flag), .irq(irq),
        .match_data(match_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_hit(input bit om, input int k, input int m, input int r);
        int eqb;
        eqb = ~(r ^ m) & k & ((1 << W) - 1);
        if (om) return eqb != 0;
        return eqb == k;
    endfunction

    // open a session: leaves the negedge where poll_req should be high
    task automatic begin_session();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // from a request cycle: clear flag, deliver a response, land on next negedge
    task automatic poll_once(input logic [W-1:0] r, input bit clr_now);
        flag_clr = clr_now;
        @(negedge clk);
        flag_clr = 1'b0;
        rsp_valid = 1'b1;
        rsp_data = r;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (2) @(negedge clk);
        chk("R9 poll_req", poll_req, 0);
        chk("R9 busy", busy, 0);
        chk("R9 match_flag", match_flag, 0);
        chk("R9 irq", irq, 0);
        chk("R9 match_data", match_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: start ignored outside polling mode / when disabled
        enable = 1'b1; func_mode = 2'b01;
        begin_session();
        chk("R6 wrong mode busy", busy, 0);
        chk("R6 wrong mode req", poll_req, 0);
        enable = 1'b0; func_mode = 2'b10;
        begin_session();
        chk("R6 disabled busy", busy, 0);
        enable = 1'b1;

        // R1/R2: exhaustive sweep in continuous mode
        stop_on_match = 1'b0;
        for (int om = 0; om < 2; om++) begin
            for (int k = 0; k < 16; k++) begin
                for (int m = 0; m < 16; m++) begin
                    or_mode = om[0]; mask = k[W-1:0]; match_val = m[W-1:0];
                    begin_session();
                    for (int r = 0; r < 16; r++) begin
                        bit e;
                        e = exp_hit(om[0], k, m, r);
                        if (!poll_req) chk("R8 req after result", poll_req, 1);
                        poll_once(r[W-1:0], 1'b1);
                        if (om == 0) chk("R1 and-mode flag", match_flag, int'(e));
                        else         chk("R2 or-mode flag", match_flag, int'(e));
                        if (e && match_data != r[W-1:0])
                            chk("R7 captured word", match_data, r);
                    end
                    // R4: abort ends the continuous session
                    abort = 1'b1;
                    @(negedge clk) abort = 1'b0;
                    if (busy || poll_req) chk("R4 abort busy", busy, 0);
                    flag_clr = 1'b1;
                    @(negedge clk) flag_clr = 1'b0;
                end
            end
        end

        // R4: continuous mode keeps polling after a match
        or_mode = 1'b0; mask = 4'hF; match_val = 4'h5;
        begin_session();
        poll_once(4'h5, 1'b1);
        chk("R4 still busy after match", busy, 1);
        chk("R4 next request after match", poll_req, 1);
        // R8: no request while awaiting a result
        @(negedge clk);
        chk("R8 request pulse width", poll_req, 0);
        repeat (5) @(negedge clk);
        chk("R8 no req while waiting", poll_req, 0);
        chk("R8 still busy waiting", busy, 1);
        // R4: abort while a result is outstanding
        abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        chk("R4 abort busy", busy, 0);
        repeat (4) @(negedge clk);
        chk("R4 no req after abort", poll_req, 0);

        // R7: sticky flag and held data
        chk("R7 flag sticky", match_flag, 1);
        chk("R7 data kept", match_data, 5);
        // R5: interrupt gating
        irq_en = 1'b0; #1;
        chk("R5 irq masked", irq, 0);
        irq_en = 1'b1; #1;
        chk("R5 irq raised", irq, 1);
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk("R7 cleared", match_flag, 0);
        chk("R5 irq follows flag", irq, 0);

        // R7: match wins over simultaneous clear; data held over miss
        begin_session();
        @(negedge clk);
        flag_clr = 1'b1; rsp_valid = 1'b1; rsp_data = 4'h5;
        @(negedge clk);
        flag_clr = 1'b0; rsp_valid = 1'b0;
        chk("R7 set wins over clear", match_flag, 1);
        poll_once(4'h3, 1'b0);
        chk("R7 data held on miss", match_data, 5);
        chk("R7 flag held on miss", match_flag, 1);

        // R6: disable mid-session
        enable = 1'b0;
        @(negedge clk);
        chk("R6 disable ends", busy, 0);
        enable = 1'b1;
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;

        // R3: auto-stop on first match
        stop_on_match = 1'b1;
        begin_session();
        poll_once(4'h4, 1'b0);
        chk("R3 miss keeps polling", poll_req, 1);
        poll_once(4'h5, 1'b0);
        chk("R3 busy after match", busy, 0);
        chk("R3 flag", match_flag, 1);
        repeat (5) @(negedge clk);
        chk("R3 no req after stop", poll_req, 0);

        // R6: mode change mid-session
        begin_session();
        func_mode = 2'b11;
        @(negedge clk);
        chk("R6 mode change ends", busy, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule